// File: doc/BRIEF.md
# Memory Wait-State Generator

This block stretches processor bus cycles that address slow memory. The address decoder raises one select line per memory region. While a select is active the block holds the processor's ready input low, and it releases ready once the selected region's programmed number of clock edges has passed. The processor adds one wait clock after its third bus state for every clock in which ready is sampled low. Fast regions have a wait count of zero and so never see ready drop.

Every clocked flop of a shift chain marks one wait clock. The first stage loads from the OR of the region selects, and each later stage follows the stage before it. A tap picks the stage that matches the selected region's count. When every select is inactive the chain clears synchronously, so the next access counts from zero again. The wait counts are static configuration inputs, one field per region, and only change while no select is active. The decoder drives at most one select at a time, and the selects return low between bus cycles.

Top module: `ws_wait_gen`

## Requirements
- R1: With no select active, `ready` is high.
- R2: In the cycle in which a select first rises, `ready` goes low at once, before any clock edge, when that region's wait count N is 1 to 3.
- R3: With the select held, `ready` stays low for exactly N rising edges and is high from the N-th rising edge on.
- R4: A region with N = 0 never drives `ready` low.
- R5: Dropping the select for even one cycle clears the chain. A select that rises again waits the full N edges, even if the earlier count was cut short.
- R6: The wait count used is the field of the active region. Field k occupies bits [2k+1:2k] of `region_waits` (2-bit unsigned, default of 4 regions).
- R7: While `rst` is high, `ready` is high. A rising edge with `rst` high clears the chain, so counting restarts from the first edge after `rst` falls.
- R8: Once `ready` has risen during a held select, it stays high until the select drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| region_sel | input | NUM_REGIONS | Decoded region selects, at most one high |
| region_waits | input | NUM_REGIONS*WAIT_W | Per-region wait count, field k at [WAIT_W*k +: WAIT_W] |
| ready | output | 1 | Processor ready, low inserts a wait clock |

## Verification
A stage of the chain stuck or skipped moves the rising edge of `ready` by one or more clocks from the N-th edge. This shows as a wrong value in the very cycle where the select has been held N edges. A chain that fails to clear shows on the next access as a `ready` that is high too early, right in the first cycle after the select rises again. A wrong field selection shows as an access that waits for another region's count. A sweep of every region against every count, with short gaps and aborted counts, exposes each of these within one bus cycle.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int DEF_REGIONS  = 4;
  localparam int DEF_MAX_WAIT = 3;

  function automatic int wait_width(input int max_wait);
    return (max_wait < 1) ? 1 : $clog2(max_wait + 1);
  endfunction
endpackage

// File: rtl/ws_region_mux.sv
module ws_region_mux #(
  parameter int NUM_REGIONS = 4,
  parameter int WAIT_W      = 2
) (
  input  logic [NUM_REGIONS-1:0]        region_sel,
  input  logic [NUM_REGIONS*WAIT_W-1:0] region_waits,
  output logic [WAIT_W-1:0]             wait_n
);
  // One-hot select: AND-OR of masked fields.
  always_comb begin
    wait_n = '0;
    for (int k = 0; k < NUM_REGIONS; k++) begin
      if (region_sel[k]) wait_n = wait_n | region_waits[WAIT_W*k +: WAIT_W];
    end
  end
endmodule

// File: rtl/ws_delay_chain.sv
module ws_delay_chain #(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [DEPTH-1:0] stage
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic d;
    if (i == 0) begin : g_head
      assign d = start;
    end else begin : g_link
      assign d = stage[i-1];
    end
    // Each flop clears whenever the select is gone.
    always_ff @(posedge clk) begin
      if (rst || !start) stage[i] <= 1'b0;
      else               stage[i] <= d;
    end
  end
endmodule

// File: rtl/ws_ready_tap.sv
module ws_ready_tap #(
  parameter int DEPTH  = 3,
  parameter int WAIT_W = 2
) (
  input  logic [DEPTH-1:0]  stage,
  input  logic [WAIT_W-1:0] wait_n,
  output logic              done
);
  always_comb begin
    done = (wait_n == '0);
    for (int i = 0; i < DEPTH; i++) begin
      if (wait_n == WAIT_W'(i + 1)) done = stage[i];
    end
  end
endmodule

// File: rtl/ws_wait_gen.sv
module ws_wait_gen #(
  parameter int NUM_REGIONS = ws_pkg::DEF_REGIONS,
  parameter int MAX_WAIT    = ws_pkg::DEF_MAX_WAIT,
  parameter int WAIT_W      = ws_pkg::wait_width(MAX_WAIT)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_REGIONS-1:0]        region_sel,
  input  logic [NUM_REGIONS*WAIT_W-1:0] region_waits,
  output logic                          ready
);
  localparam int DEPTH = (MAX_WAIT < 1) ? 1 : MAX_WAIT;

  logic              any_sel;
  logic [WAIT_W-1:0] wait_n;
  logic [DEPTH-1:0]  stage;
  logic              done;

  assign any_sel = |region_sel;

  ws_region_mux #(.NUM_REGIONS(NUM_REGIONS), .WAIT_W(WAIT_W)) u_mux (
    .region_sel   (region_sel),
    .region_waits (region_waits),
    .wait_n       (wait_n)
  );

  ws_delay_chain #(.DEPTH(DEPTH)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .start (any_sel),
    .stage (stage)
  );

  ws_ready_tap #(.DEPTH(DEPTH), .WAIT_W(WAIT_W)) u_tap (
    .stage  (stage),
    .wait_n (wait_n),
    .done   (done)
  );

  assign ready = rst || !any_sel || done;
endmodule

// File: rtl/ws_wait_gen_chk.sv
module ws_wait_gen_chk #(
  parameter int NUM_REGIONS = 4,
  parameter int MAX_WAIT    = 3,
  parameter int WAIT_W      = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_REGIONS-1:0]        region_sel,
  input logic [NUM_REGIONS*WAIT_W-1:0] region_waits,
  input logic                          ready
);
  logic              sel_on;
  logic [WAIT_W-1:0] exp_n;
  logic [WAIT_W-1:0] held;

  assign sel_on = |region_sel;

  always_comb begin
    exp_n = '0;
    for (int k = 0; k < NUM_REGIONS; k++)
      if (region_sel[k]) exp_n = region_waits[WAIT_W*k +: WAIT_W];
  end

  // Edges seen with the select held, saturating.
  always_ff @(posedge clk) begin
    if (rst || !sel_on)              held <= '0;
    else if (held != {WAIT_W{1'b1}}) held <= held + 1'b1;
  end

  a_r1_idle_ready: assert property (@(posedge clk) disable iff (rst)
    !sel_on |-> ready);
  a_r2_wait_low: assert property (@(posedge clk) disable iff (rst)
    (sel_on && held < exp_n) |-> !ready);
  a_r3_release: assert property (@(posedge clk) disable iff (rst)
    (sel_on && held >= exp_n) |-> ready);
  a_r4_zero_wait: assert property (@(posedge clk) disable iff (rst)
    (sel_on && exp_n == '0) |-> ready);
  a_r7_reset_ready: assert property (@(posedge clk)
    rst |-> ready);
  a_r8_stays_high: assert property (@(posedge clk) disable iff (rst)
    (sel_on && ready) |=> (!sel_on || ready));
endmodule

bind ws_wait_gen ws_wait_gen_chk #(
  .NUM_REGIONS(NUM_REGIONS), .MAX_WAIT(MAX_WAIT), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst(rst), .region_sel(region_sel),
  .region_waits(region_waits), .ready(ready)
);

// File: tb/ws_wait_gen_test.sv
`timescale 1ns/1ps
module ws_wait_gen_test;
  localparam int NR = 4;
  localparam int WW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NR-1:0] region_sel = '0;
  logic [NR*WW-1:0] region_waits = '0;
  logic          ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ws_wait_gen uut (
    .clk(clk), .rst(rst), .region_sel(region_sel),
    .region_waits(region_waits), .ready(ready)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (ready !== exp) begin
      errors++;
      $display("FAIL %s: ready=%b expected %b at %0t", req, ready, exp, $time);
    end
  endtask

  // Hold select of region r for hold cycles, expecting N waits.
  task automatic access(input int r, input int n, input int hold, input string req);
    @(negedge clk);
    region_sel = NR'(1) << r;
    for (int k = 0; k < hold; k++) begin
      #1;
      check(req, (n == 0) || (k >= n));
      @(negedge clk);
    end
    region_sel = '0;
    #1;
    check("R1", 1'b1);
  endtask

  initial begin
    #1;
    check("R7", 1'b1);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", 1'b1);

    // R3 R4 R6: each region against each count, rotated so regions differ.
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < NR; r++) region_waits[WW*r +: WW] = WW'((r + s) % 4);
      for (int r = 0; r < NR; r++) begin
        access(r, (r + s) % 4, 5, ((r + s) % 4 == 0) ? "R4" : "R3_R6");
      end
    end

    // R2: low in the rising cycle, before any edge.
    region_waits = {2'd3, 2'd2, 2'd1, 2'd3};
    @(negedge clk);
    #5;
    region_sel = 4'b0001;
    #1;
    check("R2", 1'b0);
    @(negedge clk);
    region_sel = '0;
    #1;
    check("R1", 1'b1);

    // R5: aborted count, one-cycle gap, then full count again.
    access(0, 3, 2, "R5");
    access(0, 3, 5, "R5");
    access(2, 2, 1, "R5");
    access(2, 2, 4, "R5");

    // R8: long hold stays high.
    access(1, 1, 10, "R8");

    // R7: reset mid-count.
    @(negedge clk);
    region_sel = 4'b1000;
    #1;
    check("R2", 1'b0);
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R7", 1'b1);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      #1;
      check("R7", k >= 3);
      @(negedge clk);
    end
    region_sel = '0;
    #1;
    check("R1", 1'b1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: ready=%b expected finish", ready);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule